// File: doc/BRIEF.md
# Highest-Priority Pending Interrupt Selector

This block looks at a set of interrupt sources on behalf of each of several processors and names, for each processor, the single source it should service next. Every source carries, per processor, an enable flag, a pending flag and an 8-bit urgency value, where a smaller value is more urgent. For each processor the block finds the most urgent source that is both enabled and pending. It reports that source's number, or 1023 when there is none. It raises that processor's request line only when the winner is urgent enough to interrupt the work already running there.

Two thresholds per processor decide what is seen. A mask value limits which winners are reported at all. A running priority, nine bits wide so that 0x100 can mean "nothing running", limits which reported winners actually raise the request. A global enable and a per-processor enable can each silence a processor completely. The register file, the acknowledge and completion logic, and input sampling are outside this block. They drive its inputs as plain vectors, and the outputs are registered so that a downstream register read sees a stable value.

Top module: `hps_select`

## Requirements
- R1: For a processor, a source takes part in the selection only when its enable bit and its pending bit for that processor are both 1.
- R2: Among the taking-part sources, the one with the smallest priority value wins. When two or more share that smallest value, the lowest source number wins.
- R3: When no source takes part for a processor, its reported ID is 1023 and its request line is 0.
- R4: The winner's ID is reported only when the winner's priority is less than or equal to the processor's 8-bit mask value. Otherwise the reported ID is 1023 and the request is 0.
- R5: The request line is 1 only when a winner is reported and its priority is strictly less than the processor's 9-bit running priority. A running priority of 0x100 means nothing is running.
- R6: When the global enable is 0, or the processor's own enable is 0, that processor's reported ID is 1023 and its request is 0.
- R7: Both outputs are registered. They show the result for the inputs present at the previous rising clock edge. During and after reset they read ID 1023 and request 0.
- R8: Each processor's outputs depend only on that processor's own enable bits, pending bits, priorities, mask and running priority, together with the global enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| dist_en | input | 1 | Global enable for all processors |
| cpu_en | input | NUM_CPU | Per-processor enable |
| src_en | input | NUM_CPU*NUM_SRC | Enable bits, bit c*NUM_SRC+s is source s for processor c |
| src_pend | input | NUM_CPU*NUM_SRC | Pending bits, same indexing as src_en |
| src_prio | input | NUM_CPU*NUM_SRC*8 | Priority of source s for processor c at bits [(c*NUM_SRC+s)*8 +: 8] |
| prio_mask | input | NUM_CPU*8 | Mask value of processor c at bits [c*8 +: 8] |
| run_prio | input | NUM_CPU*9 | Running priority of processor c at bits [c*9 +: 9] |
| hp_id | output | NUM_CPU*10 | Reported ID of processor c at bits [c*10 +: 10], 1023 when none |
| irq_req | output | NUM_CPU | Request line per processor |

## Verification
The tie-break and the threshold comparisons can act in the same cycle. A tie on the smallest priority value can coincide with that value sitting exactly on the mask, or exactly on the running priority. Directed steps set up both cases, and a long random run draws priorities, masks and running priorities from a small alphabet so that ties and equal thresholds happen often. A plain ascending scan in the bench serves as the reference model for the reported ID and the request line of each processor.

// File: rtl/hps_pkg.sv
package hps_pkg;
  localparam int PRIO_W      = 8;
  localparam int RUN_W       = PRIO_W + 1;
  localparam int ID_W        = 10;
  localparam int SPURIOUS_ID = 1023;
  localparam int IDLE_PRIO   = 1 << PRIO_W;

  typedef struct packed {
    logic [RUN_W-1:0] prio;
    logic [ID_W-1:0]  id;
  } cand_t;

  function automatic cand_t no_cand();
    cand_t r;
    r.prio = RUN_W'(IDLE_PRIO);
    r.id   = ID_W'(SPURIOUS_ID);
    return r;
  endfunction

  // Leaf of the selection tree: an idle candidate unless enabled and pending.
  function automatic cand_t make_leaf(logic en, logic pend,
                                      logic [PRIO_W-1:0] pr,
                                      logic [ID_W-1:0] id);
    cand_t r;
    if (en && pend) begin
      r.prio = {1'b0, pr};
      r.id   = id;
    end else begin
      r = no_cand();
    end
    return r;
  endfunction

  // Left operand carries the lower IDs, so it keeps ties.
  function automatic cand_t pick_better(cand_t lo_side, cand_t hi_side);
    return (lo_side.prio <= hi_side.prio) ? lo_side : hi_side;
  endfunction

  function automatic logic within_mask(logic [RUN_W-1:0] p,
                                       logic [PRIO_W-1:0] m);
    return p <= {1'b0, m};
  endfunction

  function automatic logic can_preempt(logic [RUN_W-1:0] p,
                                       logic [RUN_W-1:0] running);
    return p < running;
  endfunction
endpackage

// File: rtl/hps_scan.sv
module hps_scan
  import hps_pkg::*;
#(
  parameter int NUM_SRC = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SRC-1:0]        en,
  input  logic [NUM_SRC-1:0]        pend,
  input  logic [NUM_SRC*PRIO_W-1:0] prio,
  output cand_t                     win
);
  localparam int LEVELS = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int LEAVES = 1 << LEVELS;

  cand_t node [1:2*LEAVES-1];

  genvar k;
  generate
    for (k = 0; k < LEAVES; k++) begin : g_leaf
      if (k < NUM_SRC) begin : g_real
        assign node[LEAVES+k] = make_leaf(en[k], pend[k],
                                          prio[k*PRIO_W +: PRIO_W],
                                          ID_W'(k));
      end else begin : g_pad
        assign node[LEAVES+k] = no_cand();
      end
    end
    for (k = 1; k < LEAVES; k++) begin : g_node
      assign node[k] = pick_better(node[2*k], node[2*k+1]);
    end
  endgenerate

  assign win = node[1];

  // Independent linear view of the same inputs, for the checks below.
  logic beats_win;
  logic win_is_real;
  always_comb begin
    beats_win   = 1'b0;
    win_is_real = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (en[i] && pend[i]) begin
        if ({1'b0, prio[i*PRIO_W +: PRIO_W]} < win.prio)
          beats_win = 1'b1;
        if (({1'b0, prio[i*PRIO_W +: PRIO_W]} == win.prio) &&
            (ID_W'(i) < win.id))
          beats_win = 1'b1;
        if ((ID_W'(i) == win.id) &&
            ({1'b0, prio[i*PRIO_W +: PRIO_W]} == win.prio))
          win_is_real = 1'b1;
      end
    end
  end

  AST_NO_BETTER_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    !beats_win); // R2
  AST_WIN_IS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (win.prio != RUN_W'(IDLE_PRIO)) |-> win_is_real); // R1
  AST_IDLE_IS_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (win.prio == RUN_W'(IDLE_PRIO)) |-> (win.id == ID_W'(SPURIOUS_ID))); // R3
endmodule

// File: rtl/hps_gate.sv
module hps_gate
  import hps_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dist_en,
  input  logic              cpu_en,
  input  cand_t             win,
  input  logic [PRIO_W-1:0] mask,
  input  logic [RUN_W-1:0]  run_prio,
  output logic [ID_W-1:0]   hp_id,
  output logic              req
);
  logic live;
  logic shown;
  logic fire;

  assign live  = dist_en && cpu_en;
  assign shown = live && within_mask(win.prio, mask);
  assign fire  = shown && can_preempt(win.prio, run_prio);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hp_id <= ID_W'(SPURIOUS_ID);
      req   <= 1'b0;
    end else begin
      hp_id <= shown ? win.id : ID_W'(SPURIOUS_ID);
      req   <= fire;
    end
  end

  AST_REQ_HAS_ID: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> (hp_id != ID_W'(SPURIOUS_ID))); // R5
  AST_OFF_IS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !live |=> (!req && hp_id == ID_W'(SPURIOUS_ID))); // R6
  AST_MASK_HIDES: assert property (@(posedge clk) disable iff (!rst_n)
    (win.prio > {1'b0, mask}) |=> (hp_id == ID_W'(SPURIOUS_ID))); // R4
  AST_NO_PREEMPT_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (win.prio >= run_prio) |=> !req); // R5
endmodule

// File: rtl/hps_select.sv
module hps_select
  import hps_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int NUM_CPU = 2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              dist_en,
  input  logic [NUM_CPU-1:0]                cpu_en,
  input  logic [NUM_CPU*NUM_SRC-1:0]        src_en,
  input  logic [NUM_CPU*NUM_SRC-1:0]        src_pend,
  input  logic [NUM_CPU*NUM_SRC*PRIO_W-1:0] src_prio,
  input  logic [NUM_CPU*PRIO_W-1:0]         prio_mask,
  input  logic [NUM_CPU*RUN_W-1:0]          run_prio,
  output logic [NUM_CPU*ID_W-1:0]           hp_id,
  output logic [NUM_CPU-1:0]                irq_req
);
  localparam int SRC_PRIO_BITS = NUM_SRC * PRIO_W;

  genvar c;
  generate
    for (c = 0; c < NUM_CPU; c++) begin : g_cpu
      cand_t win;

      hps_scan #(.NUM_SRC(NUM_SRC)) u_scan (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (src_en[c*NUM_SRC +: NUM_SRC]),
        .pend (src_pend[c*NUM_SRC +: NUM_SRC]),
        .prio (src_prio[c*SRC_PRIO_BITS +: SRC_PRIO_BITS]),
        .win  (win)
      );

      hps_gate u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .dist_en (dist_en),
        .cpu_en  (cpu_en[c]),
        .win     (win),
        .mask    (prio_mask[c*PRIO_W +: PRIO_W]),
        .run_prio(run_prio[c*RUN_W +: RUN_W]),
        .hp_id   (hp_id[c*ID_W +: ID_W]),
        .req     (irq_req[c])
      );
    end
  endgenerate
endmodule

// File: tb/hps_select_bench.sv
module hps_select_bench;
  localparam int NS = 12;
  localparam int NC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dist_en;
  logic [NC-1:0] cpu_en;
  logic [NC*NS-1:0] src_en, src_pend;
  logic [NC*NS*8-1:0] src_prio;
  logic [NC*8-1:0] prio_mask;
  logic [NC*9-1:0] run_prio;
  logic [NC*10-1:0] hp_id;
  logic [NC-1:0] irq_req;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  hps_select #(.NUM_SRC(NS), .NUM_CPU(NC)) u_hps_select (
    .clk(clk), .rst_n(rst_n), .dist_en(dist_en), .cpu_en(cpu_en),
    .src_en(src_en), .src_pend(src_pend), .src_prio(src_prio),
    .prio_mask(prio_mask), .run_prio(run_prio),
    .hp_id(hp_id), .irq_req(irq_req)
  );

  // Reference: ascending scan, strict improvement only.
  function automatic int best_prio(int c);
    int b = 256;
    for (int s = 0; s < NS; s++)
      if (src_en[c*NS+s] && src_pend[c*NS+s] && int'(src_prio[(c*NS+s)*8 +: 8]) < b)
        b = int'(src_prio[(c*NS+s)*8 +: 8]);
    return b;
  endfunction

  function automatic int best_src(int c);
    int b = 256;
    int id = 1023;
    for (int s = 0; s < NS; s++)
      if (src_en[c*NS+s] && src_pend[c*NS+s] && int'(src_prio[(c*NS+s)*8 +: 8]) < b) begin
        b = int'(src_prio[(c*NS+s)*8 +: 8]);
        id = s;
      end
    return id;
  endfunction

  function automatic int exp_id(int c);
    if (!dist_en || !cpu_en[c]) return 1023;
    if (best_prio(c) > int'(prio_mask[c*8 +: 8])) return 1023;
    return best_src(c);
  endfunction

  function automatic bit exp_req(int c);
    return exp_id(c) != 1023 && best_prio(c) < int'(run_prio[c*9 +: 9]);
  endfunction

  task automatic check(string tag, int actual, int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  task automatic clear_all();
    dist_en = 1'b1; cpu_en = '1; src_en = '0; src_pend = '0;
    src_prio = '0; prio_mask = {NC{8'hFF}}; run_prio = {NC{9'h100}};
  endtask

  task automatic set_src(int c, int s, bit en, bit pd, int pr);
    src_en[c*NS+s] = en;
    src_pend[c*NS+s] = pd;
    src_prio[(c*NS+s)*8 +: 8] = 8'(pr);
  endtask

  // Inputs were set just after a falling edge; one rising edge registers them.
  task automatic step_check(string tag, int c, int id_e, bit req_e);
    @(posedge clk); @(negedge clk);
    check({tag, " id"}, int'(hp_id[c*10 +: 10]), id_e);
    check({tag, " req"}, int'(irq_req[c]), int'(req_e));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL R7 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    clear_all();
    repeat (3) @(negedge clk);
    for (int c = 0; c < NC; c++) begin
      check("R7 reset id", int'(hp_id[c*10 +: 10]), 1023);
      check("R7 reset req", int'(irq_req[c]), 0);
    end
    rst_n = 1'b1;
    @(negedge clk);

    step_check("R3 empty", 0, 1023, 0);

    set_src(0, 3, 1, 0, 0);
    set_src(0, 5, 0, 1, 0);
    set_src(0, 7, 1, 1, 8'h80);
    step_check("R1 filter", 0, 7, 1);

    set_src(0, 9, 1, 1, 8'h20);
    set_src(0, 4, 1, 1, 8'h20);
    step_check("R2 tie lowest id", 0, 4, 1);
    set_src(0, 11, 1, 1, 8'h10);
    step_check("R2 lower value", 0, 11, 1);

    prio_mask[7:0] = 8'h10;
    step_check("R4 mask equal", 0, 11, 1);
    prio_mask[7:0] = 8'h0F;
    step_check("R4 mask below", 0, 1023, 0);
    prio_mask[7:0] = 8'hFF;

    run_prio[8:0] = 9'h010;
    step_check("R5 run equal", 0, 11, 0);
    run_prio[8:0] = 9'h011;
    step_check("R5 run above", 0, 11, 1);
    run_prio[8:0] = 9'h100;

    set_src(1, 2, 1, 1, 8'h40);
    step_check("R8 cpu1", 1, 2, 1);
    check("R8 cpu0 kept", int'(hp_id[9:0]), 11);

    cpu_en[0] = 1'b0;
    step_check("R6 cpu off", 0, 1023, 0);
    check("R6 other cpu", int'(hp_id[19:10]), 2);
    cpu_en[0] = 1'b1;
    dist_en = 1'b0;
    step_check("R6 dist off", 1, 1023, 0);
    dist_en = 1'b1;
    step_check("R6 back on", 0, 11, 1);

    set_src(0, 0, 1, 1, 8'h00);
    #1;
    check("R7 before edge", int'(hp_id[9:0]), 11);
    step_check("R7 after edge", 0, 0, 1);

    for (int it = 0; it < 2000; it++) begin
      automatic int alpha[6] = '{8'h00, 8'h10, 8'h10, 8'h7F, 8'hFE, 8'hFF};
      dist_en = ($urandom % 16) != 0;
      cpu_en = NC'($urandom) | NC'($urandom);
      src_en = {$urandom, $urandom};
      src_pend = {$urandom, $urandom};
      for (int k = 0; k < NC*NS; k++)
        src_prio[k*8 +: 8] = 8'(alpha[$urandom % 6]);
      for (int c = 0; c < NC; c++) begin
        prio_mask[c*8 +: 8] = 8'(alpha[$urandom % 6]);
        run_prio[c*9 +: 9] = ($urandom % 4 == 0) ? 9'h100 : 9'(alpha[$urandom % 6]);
      end
      @(posedge clk); @(negedge clk);
      for (int c = 0; c < NC; c++) begin
        check("R2 random id", int'(hp_id[c*10 +: 10]), exp_id(c));
        check("R5 random req", int'(irq_req[c]), int'(exp_req(c)));
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule